// File: doc/BRIEF.md
# Data TLB with ASID-to-ring qualification

This block translates data-side virtual addresses through a small set-associative TLB. A parameter sets the number of refillable ways (four by default). Every way holds 4 KB pages, and all ways are searched in parallel with the same index bits. Each entry stores a virtual tag, a physical page number, an 8-bit address-space identifier and a 4-bit attribute code.

A 32-bit ring-identifier register holds one identifier per privilege ring: byte 0 belongs to ring 0 and byte 3 to ring 3. An entry can only hit while its identifier appears somewhere in that register, and the index of the matching byte becomes the ring of the hit. The block then checks the ring against the requester's current ring and the attribute code against the kind of access. It returns either the physical address or a fault cause.

The same request port also accepts entry writes, entry invalidations and probes. Write, invalidate and lookup go through the same request port as probes. There is one operation per cycle. Lookups and probes answer from registers one cycle later.

Top module: `dtlb_ring_tlb`

## Requirements
- R1: After a synchronous reset, every entry holds identifier 0 and `ring_ids` reads 0x04030201, so any lookup returns cause 1 (miss).
- R2: A write to the ring-identifier register stores bits [31:8] of the data and forces bits [7:0] to 0x01. The new value is visible on `ring_ids` in the next cycle and takes effect for requests from the next cycle on.
- R3: A write request (`req_op`=2) fills the entry `req_way` at index `req_vaddr[13:12]` (or `[14:12]` with 8 entries per way). The tag is taken from the address bits above the index, and the page number from `req_pte[31:12]`. The identifier is the byte of `ring_ids` selected by `req_pte[5:4]`, and the attribute is `req_pte[3:0]`.
- R4: A lookup (`req_op`=0) that hits exactly one way with sufficient ring and rights returns `rsp_valid`=1 one cycle after the request. It also returns cause 0, `rsp_paddr` = {page number, `req_vaddr[11:0]`}, and `rsp_ring` = the index of the lowest byte of `ring_ids` equal to the entry's identifier.
- R5: An entry with identifier 0, or one whose identifier equals no byte of `ring_ids`, never hits, and a lookup that hits nothing returns cause 1.
- R6: A lookup hitting two or more ways returns cause 2. A probe hitting two or more ways also returns cause 2, with result 0.
- R7: A single hit whose ring is numerically below `req_ring` returns cause 3. This check comes before the rights check.
- R8: For attribute codes below 12, read is allowed, bit 0 grants execute and bit 1 grants write. Code 13 grants read and write only, and every other code grants nothing. `req_access` is 0 for read, 1 for write, 2 for execute, and 3 is never granted. A lookup that is refused returns cause 4.
- R9: An invalidate request (`req_op`=3) sets the identifier of entry `req_way` at the indexed slot to 0. Later lookups then no longer hit it.
- R10: A probe (`req_op`=1) with a single hit whose ring is at least `req_ring` returns `rsp_paddr` = `req_vaddr[31:12]`<<12 | 0x10 | way number, with cause 0. Any other probe returns 0.
- R11: Write, invalidate and idle cycles give `rsp_valid`=0 in the next cycle. Any response with a nonzero cause carries `rsp_paddr`=0, and `rsp_ring` is the hit ring only when exactly one way hit, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_we | input | 1 | Write enable for the ring-identifier register |
| ring_wdata | input | 32 | Data for the ring-identifier register |
| ring_ids | output | 32 | Current ring-identifier register |
| req_valid | input | 1 | Request valid |
| req_op | input | 2 | 0 lookup, 1 probe, 2 write entry, 3 invalidate entry |
| req_way | input | 2 | Way targeted by write or invalidate |
| req_vaddr | input | 32 | Virtual address |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_ring | input | 2 | Current privilege ring of the requester |
| req_pte | input | 32 | Page-table entry for writes |
| rsp_valid | output | 1 | Response valid, one cycle after a lookup or probe |
| rsp_paddr | output | 32 | Physical address, or probe result |
| rsp_cause | output | 3 | 0 ok, 1 miss, 2 multi-hit, 3 privilege, 4 prohibited |
| rsp_ring | output | 2 | Ring of the single hit |

## Verification
Every lookup or probe response is due exactly one rising edge after the request, and a ring-register write shows on `ring_ids` after that same edge. An entry write or invalidate changes the answer to a request issued in the following cycle. The bench model applies every operation at the edge where the design registers it. Expected values come from the model state before that edge. The bench compares all outputs on the falling edge that follows, on every cycle.

// File: rtl/dtlb_ring_pkg.sv
package dtlb_ring_pkg;
  localparam int PAGE_W = 12;
  localparam int VA_W   = 32;
  localparam int PPN_W  = VA_W - PAGE_W;

  localparam logic [1:0] OP_LOOKUP = 2'd0;
  localparam logic [1:0] OP_PROBE  = 2'd1;
  localparam logic [1:0] OP_WRITE  = 2'd2;
  localparam logic [1:0] OP_INVAL  = 2'd3;

  localparam logic [2:0] CAUSE_OK    = 3'd0;
  localparam logic [2:0] CAUSE_MISS  = 3'd1;
  localparam logic [2:0] CAUSE_MULTI = 3'd2;
  localparam logic [2:0] CAUSE_PRIV  = 3'd3;
  localparam logic [2:0] CAUSE_DENY  = 3'd4;

  // {found, ring}: lowest byte of ids equal to the identifier
  function automatic logic [2:0] ring_of(input logic [7:0] id, input logic [31:0] ids);
    logic [2:0] r;
    r = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      if (ids[8*i +: 8] == id) r = {1'b1, 2'(i)};
    end
    return r;
  endfunction

  // {exec, write, read}
  function automatic logic [2:0] attr_rights(input logic [3:0] a);
    logic [2:0] g;
    g = 3'b000;
    if (a < 4'd12) g = {a[0], a[1], 1'b1};
    else if (a == 4'd13) g = 3'b011;
    return g;
  endfunction
endpackage

// File: rtl/dtlb_ring_reg.sv
module dtlb_ring_reg #(
  parameter logic [31:0] RESET_IDS = 32'h0403_0201
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] ids
);
  logic unused_low;
  assign unused_low = ^wdata[7:0];

  always_ff @(posedge clk) begin
    if (rst) ids <= RESET_IDS;
    else if (we) ids <= {wdata[31:8], 8'h01};
  end
endmodule

// File: rtl/dtlb_way.sv
module dtlb_way
  import dtlb_ring_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [7:0]       wr_id,
  input  logic [3:0]       wr_attr,
  input  logic [31:0]      ring_ids,
  output logic             hit,
  output logic [1:0]       hit_ring,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [3:0]       hit_attr
);
  // Payload arrays have no reset so they map onto distributed RAM.
  logic [TAG_W-1:0] tag_mem  [ENTRIES];
  logic [PPN_W-1:0] ppn_mem  [ENTRIES];
  logic [3:0]       attr_mem [ENTRIES];
  // Identifiers carry the valid meaning and are cleared on reset.
  logic [7:0]       id_q     [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[idx]  <= tag;
      ppn_mem[idx]  <= wr_ppn;
      attr_mem[idx] <= wr_attr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) id_q[e] <= 8'h00;
    end else if (wr_en) begin
      id_q[idx] <= wr_id;
    end else if (inv_en) begin
      id_q[idx] <= 8'h00;
    end
  end

  logic [2:0] rmap;
  always_comb begin
    rmap     = ring_of(id_q[idx], ring_ids);
    hit      = (id_q[idx] != 8'h00) && rmap[2] && (tag_mem[idx] == tag);
    hit_ring = rmap[1:0];
    hit_ppn  = ppn_mem[idx];
    hit_attr = attr_mem[idx];
  end
endmodule

// File: rtl/dtlb_ring_tlb.sv
module dtlb_ring_tlb
  import dtlb_ring_pkg::*;
#(
  parameter int WAYS        = 4,
  parameter int WAY_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ring_we,
  input  logic [31:0] ring_wdata,
  output logic [31:0] ring_ids,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [1:0]  req_way,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_access,
  input  logic [1:0]  req_ring,
  input  logic [31:0] req_pte,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic [2:0]  rsp_cause,
  output logic [1:0]  rsp_ring
);
  localparam int IDX_W = $clog2(WAY_ENTRIES);
  localparam int TAG_W = VA_W - PAGE_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic unused_pte;
  assign unused_pte = ^req_pte[11:6];

  dtlb_ring_reg u_ring (
    .clk(clk), .rst(rst), .we(ring_we), .wdata(ring_wdata), .ids(ring_ids)
  );

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [7:0]       new_id;
  assign idx    = req_vaddr[PAGE_W +: IDX_W];
  assign tag    = req_vaddr[VA_W-1 -: TAG_W];
  assign new_id = ring_ids[8*req_pte[5:4] +: 8];

  logic [WAYS-1:0]  hit;
  logic [1:0]       h_ring [WAYS];
  logic [PPN_W-1:0] h_ppn  [WAYS];
  logic [3:0]       h_attr [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic sel;
    assign sel = req_valid && (32'(req_way) == g);
    dtlb_way #(.ENTRIES(WAY_ENTRIES), .TAG_W(TAG_W)) u_way (
      .clk(clk), .rst(rst),
      .wr_en(sel && req_op == OP_WRITE),
      .inv_en(sel && req_op == OP_INVAL),
      .idx(idx), .tag(tag),
      .wr_ppn(req_pte[VA_W-1:PAGE_W]), .wr_id(new_id), .wr_attr(req_pte[3:0]),
      .ring_ids(ring_ids),
      .hit(hit[g]), .hit_ring(h_ring[g]), .hit_ppn(h_ppn[g]), .hit_attr(h_attr[g])
    );
  end

  logic [WAY_W-1:0] sel_way;
  logic [1:0]       sel_ring;
  logic [PPN_W-1:0] sel_ppn;
  logic [3:0]       sel_attr;
  logic             any_hit, one_hit, multi_hit;

  always_comb begin
    sel_way = '0; sel_ring = '0; sel_ppn = '0; sel_attr = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit[w]) begin
        sel_way  = WAY_W'(w);
        sel_ring = h_ring[w];
        sel_ppn  = h_ppn[w];
        sel_attr = h_attr[w];
      end
    end
    any_hit   = |hit;
    one_hit   = $onehot(hit);
    multi_hit = any_hit && !one_hit;
  end

  logic [2:0]  rights;
  logic        granted;
  logic        q_valid;
  logic [31:0] q_addr;
  logic [2:0]  q_cause;
  logic [1:0]  q_ring;

  always_comb begin
    rights = attr_rights(sel_attr);
    case (req_access)
      2'd0:    granted = rights[0];
      2'd1:    granted = rights[1];
      2'd2:    granted = rights[2];
      default: granted = 1'b0;
    endcase
    q_valid = req_valid && (req_op == OP_LOOKUP || req_op == OP_PROBE);
    q_addr  = '0;
    q_cause = CAUSE_OK;
    q_ring  = '0;
    if (q_valid) begin
      if (one_hit) q_ring = sel_ring;
      if (req_op == OP_LOOKUP) begin
        if (!any_hit)                q_cause = CAUSE_MISS;
        else if (multi_hit)          q_cause = CAUSE_MULTI;
        else if (sel_ring < req_ring) q_cause = CAUSE_PRIV;
        else if (!granted)           q_cause = CAUSE_DENY;
        else q_addr = {sel_ppn, req_vaddr[PAGE_W-1:0]};
      end else begin
        if (multi_hit) q_cause = CAUSE_MULTI;
        else if (one_hit && sel_ring >= req_ring)
          q_addr = {req_vaddr[VA_W-1:PAGE_W], 12'h010} | {{(32-WAY_W){1'b0}}, sel_way};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_cause <= CAUSE_OK;
      rsp_ring  <= '0;
    end else begin
      rsp_valid <= q_valid;
      rsp_paddr <= q_addr;
      rsp_cause <= q_cause;
      rsp_ring  <= q_ring;
    end
  end
endmodule

// File: rtl/dtlb_ring_tlb_chk.sv
module dtlb_ring_tlb_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] ring_ids,
  input logic        req_valid,
  input logic [1:0]  req_op,
  input logic [31:0] req_vaddr,
  input logic [1:0]  req_ring,
  input logic        rsp_valid,
  input logic [31:0] rsp_paddr,
  input logic [2:0]  rsp_cause,
  input logic [1:0]  rsp_ring
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R11
  rsp_only_for_queries_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    rsp_valid == $past(req_valid && (req_op == 2'd0 || req_op == 2'd1)));

  // R2
  ring_low_byte_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    ring_ids[7:0] == 8'h01);

  // R7
  priv_ring_below_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    (rsp_valid && rsp_cause == 3'd3) |-> (rsp_ring < $past(req_ring)));

  // R11
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    (rsp_valid && rsp_cause != 3'd0) |-> (rsp_paddr == 32'h0));

  // R4
  offset_passthru_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    (rsp_valid && rsp_cause == 3'd0 && $past(req_op) == 2'd0)
      |-> (rsp_paddr[11:0] == $past(req_vaddr[11:0])));

  // R10
  probe_format_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    (rsp_valid && $past(req_op) == 2'd1 && rsp_paddr != 32'h0)
      |-> (rsp_paddr[4] && rsp_paddr[11:5] == 7'h0 && rsp_paddr[31:12] == $past(req_vaddr[31:12])));
endmodule

bind dtlb_ring_tlb dtlb_ring_tlb_chk u_chk (
  .clk(clk), .rst(rst), .ring_ids(ring_ids), .req_valid(req_valid), .req_op(req_op),
  .req_vaddr(req_vaddr), .req_ring(req_ring), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause), .rsp_ring(rsp_ring)
);

// File: tb/dtlb_ring_tlb_test.sv
`timescale 1ns/1ps
module dtlb_ring_tlb_test;
  localparam int WAYS = 4;
  localparam int ENT  = 4;
  localparam int IDXW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        ring_we = 1'b0;
  logic [31:0] ring_wdata = '0;
  logic [31:0] ring_ids;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0, req_way = '0, req_access = '0, req_ring = '0;
  logic [31:0] req_vaddr = '0, req_pte = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_cause;
  logic [1:0]  rsp_ring;

  dtlb_ring_tlb #(.WAYS(WAYS), .WAY_ENTRIES(ENT)) uut (
    .clk(clk), .rst(rst), .ring_we(ring_we), .ring_wdata(ring_wdata), .ring_ids(ring_ids),
    .req_valid(req_valid), .req_op(req_op), .req_way(req_way), .req_vaddr(req_vaddr),
    .req_access(req_access), .req_ring(req_ring), .req_pte(req_pte),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause), .rsp_ring(rsp_ring)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_id [WAYS][ENT];
  logic [31:0] m_tag[WAYS][ENT];
  logic [31:0] m_ppn[WAYS][ENT];
  logic [31:0] m_attr[WAYS][ENT];
  logic [31:0] m_rids;
  logic        e_valid;
  logic [31:0] e_paddr;
  logic [2:0]  e_cause;
  logic [1:0]  e_ring;
  string       e_tag;

  task automatic cmp(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", e_tag, what, got, exp);
    end
  endtask

  task automatic cycle(input bit rw, input logic [31:0] rwd, input bit v, input logic [1:0] op,
                       input logic [1:0] way, input logic [31:0] va, input logic [1:0] acc,
                       input logic [1:0] rg, input logic [31:0] pte, input string tag);
    int idx, n, sw, sr, sa, a, rn;
    logic [31:0] sp, vt;
    bit r, w, x, ok;
    @(negedge clk);
    cmp("rsp_valid", 32'(rsp_valid), 32'(e_valid));
    cmp("rsp_paddr", rsp_paddr, e_paddr);
    cmp("rsp_cause", 32'(rsp_cause), 32'(e_cause));
    cmp("rsp_ring", 32'(rsp_ring), 32'(e_ring));
    cmp("ring_ids", ring_ids, m_rids);
    ring_we = rw; ring_wdata = rwd; req_valid = v; req_op = op; req_way = way;
    req_vaddr = va; req_access = acc; req_ring = rg; req_pte = pte;
    e_tag = tag; e_valid = 0; e_paddr = 0; e_cause = 0; e_ring = 0;
    idx = int'((va >> 12) & (ENT - 1));
    vt  = va >> (12 + IDXW);
    if (v && op == 2'd2) begin
      m_tag[way][idx]  = vt;
      m_ppn[way][idx]  = pte >> 12;
      m_id[way][idx]   = (m_rids >> (8 * ((pte >> 4) & 3))) & 32'hff;
      m_attr[way][idx] = pte & 32'hf;
    end else if (v && op == 2'd3) begin
      m_id[way][idx] = 0;
    end else if (v) begin
      n = 0; sw = 0; sr = 0; sa = 0; sp = 0;
      for (int k = 0; k < WAYS; k++) begin
        a = int'(m_id[k][idx]); rn = -1;
        for (int b = 0; b < 4; b++)
          if (rn < 0 && int'((m_rids >> (8 * b)) & 32'hff) == a) rn = b;
        if (a != 0 && rn >= 0 && m_tag[k][idx] == vt) begin
          if (n == 0) begin sw = k; sr = rn; sp = m_ppn[k][idx]; sa = int'(m_attr[k][idx]); end
          n++;
        end
      end
      e_valid = 1;
      if (n == 1) e_ring = 2'(sr);
      r = (sa < 12) || sa == 13;
      w = (sa < 12 && sa[1]) || sa == 13;
      x = (sa < 12 && sa[0]);
      ok = (acc == 0) ? r : (acc == 1) ? w : (acc == 2) ? x : 1'b0;
      if (op == 2'd0) begin
        if (n == 0) e_cause = 1;
        else if (n > 1) e_cause = 2;
        else if (sr < int'(rg)) e_cause = 3;
        else if (!ok) e_cause = 4;
        else e_paddr = (sp << 12) | (va & 32'hfff);
      end else begin
        if (n > 1) e_cause = 2;
        else if (n == 1 && sr >= int'(rg)) e_paddr = (va & 32'hfffff000) | 32'h10 | sw;
      end
    end
    if (rw) m_rids = {rwd[31:8], 8'h01};
  endtask

  task automatic lk(logic [31:0] va, logic [1:0] acc, logic [1:0] rg, string tag);
    cycle(0, 0, 1, 2'd0, 0, va, acc, rg, 0, tag);
  endtask
  task automatic wr(logic [1:0] way, logic [31:0] va, logic [31:0] pte, string tag);
    cycle(0, 0, 1, 2'd2, way, va, 0, 0, pte, tag);
  endtask
  task automatic pr(logic [31:0] va, logic [1:0] rg, string tag);
    cycle(0, 0, 1, 2'd1, 0, va, 0, rg, 0, tag);
  endtask
  task automatic rset(logic [31:0] d, string tag);
    cycle(1, d, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic idle(string tag);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < WAYS; k++)
      for (int e = 0; e < ENT; e++) begin
        m_id[k][e] = 0; m_tag[k][e] = 0; m_ppn[k][e] = 0; m_attr[k][e] = 0;
      end
    m_rids = 32'h0403_0201;
    e_valid = 0; e_paddr = 0; e_cause = 0; e_ring = 0; e_tag = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state and empty table
    idle("R1");
    lk(32'h1234_5000, 0, 0, "R1");
    lk(32'h0000_0000, 0, 0, "R1");
    // R2: low byte forced to 01
    rset(32'hAABB_CCFF, "R2");
    idle("R2");
    rset(32'h0403_0201, "R2");
    // R3 R4: write then hit, ring 1 via pte[5:4]=1
    wr(0, 32'h1234_5000, 32'h8765_4013, "R3");
    lk(32'h1234_5ABC, 0, 0, "R4");
    lk(32'h1234_5FFF, 1, 1, "R4");
    lk(32'h1234_5004, 2, 0, "R4");
    lk(32'h1234_9000, 0, 0, "R5");
    // R7: current ring above entry ring
    lk(32'h1234_5ABC, 0, 2, "R7");
    lk(32'h1234_5ABC, 1, 3, "R7");
    // R8: attribute decoding
    wr(1, 32'h0000_2000, 32'h1111_1000, "R3");
    lk(32'h0000_2010, 0, 0, "R8");
    lk(32'h0000_2010, 1, 0, "R8");
    lk(32'h0000_2010, 2, 0, "R8");
    lk(32'h0000_2010, 3, 0, "R8");
    wr(2, 32'h0000_3000, 32'h2222_200D, "R3");
    lk(32'h0000_3010, 0, 0, "R8");
    lk(32'h0000_3010, 1, 0, "R8");
    lk(32'h0000_3010, 2, 0, "R8");
    wr(3, 32'h0000_4000, 32'h3333_300C, "R3");
    lk(32'h0000_4010, 0, 0, "R8");
    wr(3, 32'h0000_4000, 32'h3333_300F, "R3");
    lk(32'h0000_4010, 0, 0, "R8");
    // R6: multi-hit
    wr(1, 32'h1234_5000, 32'h5555_5003, "R3");
    lk(32'h1234_5100, 0, 0, "R6");
    pr(32'h1234_5100, 0, "R6");
    // R9: invalidate
    cycle(0, 0, 1, 2'd3, 1, 32'h1234_5000, 0, 0, 0, "R9");
    lk(32'h1234_5100, 0, 0, "R9");
    cycle(0, 0, 1, 2'd3, 2, 32'h0000_3000, 0, 0, 0, "R9");
    lk(32'h0000_3000, 0, 0, "R9");
    // R5: identifier no longer in the ring register
    rset(32'h0908_0701, "R5");
    lk(32'h1234_5ABC, 0, 0, "R5");
    rset(32'h0403_0201, "R5");
    lk(32'h1234_5ABC, 0, 0, "R5");
    // R10: probe
    pr(32'h1234_5FFF, 0, "R10");
    pr(32'h1234_5FFF, 1, "R10");
    pr(32'h1234_5FFF, 2, "R10");
    pr(32'h7777_7000, 0, "R10");
    // R11: idle after writes, faults zero
    idle("R11");
    // Mixed traffic on a small address space
    for (int i = 0; i < 600; i++) begin
      logic [31:0] va, pte, rd;
      logic [1:0] op;
      va  = (32'($urandom_range(0, 3)) << 14) | (32'($urandom_range(0, 3)) << 12) | 32'($urandom_range(0, 4095));
      pte = ($urandom & 32'hffff_f000) | 32'($urandom_range(0, 63));
      op  = 2'($urandom_range(0, 3));
      rd  = {8'($urandom_range(1, 6)), 8'($urandom_range(1, 6)), 8'($urandom_range(1, 6)), 8'($urandom)};
      cycle($urandom_range(0, 15) == 0, rd, $urandom_range(0, 4) != 0, op,
            2'($urandom_range(0, 3)), va, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
            pte, "R4");
    end
    idle("R11");
    done = 1;
    summary();
    $finish;
  end
endmodule